// File: doc/BRIEF.md
# Connection Lookup Memory with Command Sequencer

This block stores up to 512 half-connections for a time-slot switch. Each entry holds a key (time slot, stream and a direction bit), a tag that points into the switch's data memory, two further control bits (pattern output and delay-buffer choice) and a 7-bit subrate field. Every entry has its own valid flag. The host builds an entry on a set of holding inputs and then starts an operation with a 3-bit opcode. The opcode can make a connection, break one, search by key, read a location, clear a location, or empty the whole memory.

Each accepted operation takes two internal cycles: a match cycle and then a retrieval/update cycle. During the first cycle the block resolves a location. For make, the location is the lowest free entry. For break and search, it is the lowest valid entry whose key matches. For read and clear, it is the supplied location index. In the second cycle the block acts on that location and latches the results into a transfer register. A make issued while every location is occupied stores nothing and raises a sticky overflow flag. The flag stays set until the host clears it.

Top module: `cam_conn_engine`

## Requirements
- R1: After reset, busy, done, err_overflow and xfer_hit are all low, and every location reads back with xfer_hit low.
- R2: A command is taken when cmd_valid is high, busy is low and cmd_op is one of 1=make, 2=break, 3=search, 4=read, 5=clear, 6=reset-all. After the accepting edge, busy is high for two cycles. On the third edge, done is high for one cycle and the results are valid. Opcodes 0 and 7 are ignored.
- R3: A cmd_valid raised while busy is high is ignored. It does not start a later command and does not change any location.
- R4: Make writes the holding fields (tag = {hold_tag_hi, hold_tag_lo}) into the lowest-indexed free location and sets its valid flag. It returns xfer_hit=1 and xfer_index set to that location. A freed location is reused.
- R5: Make with all 512 locations valid changes no location, returns xfer_hit=0 and sets err_overflow.
- R6: err_overflow stays high until err_clear is held high for one cycle. A new overflow in the same cycle wins.
- R7: Break clears the valid flag of the lowest valid location whose slot, stream and direction equal the holding fields, and returns xfer_hit=1 with its index. With no match it changes nothing and returns xfer_hit=0 and index 0.
- R8: Search compares slot, stream and direction against valid locations only. A hit returns xfer_hit=1, the lowest matching index and that entry's tag, pattern, buffer-select and subrate. A miss returns xfer_hit=0 with the index and data fields zero.
- R9: The direction bit takes part in every compare, so entries that differ only in direction are distinct.
- R10: Read returns the stored fields of location cmd_lar, with xfer_hit equal to its valid flag and xfer_index equal to cmd_lar.
- R11: Clear drops the valid flag of location cmd_lar.
- R12: Reset-all drops the valid flag of every location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code |
| cmd_lar | input | 9 | Location index for read and clear |
| hold_slot | input | 8 | Time slot of the key |
| hold_stream | input | 5 | Stream of the key |
| hold_dir | input | 1 | Direction bit of the key |
| hold_pat | input | 1 | Pattern-output control bit |
| hold_bufsel | input | 1 | Minimum/constant delay select |
| hold_tag_lo | input | 8 | Tag low bits |
| hold_tag_hi | input | 1 | Tag high bit |
| hold_subrate | input | 7 | Subrate control field |
| err_clear | input | 1 | Clears the overflow flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_overflow | output | 1 | Sticky overflow flag |
| xfer_hit | output | 1 | Hit / success / valid result |
| xfer_index | output | 9 | Location index result |
| xfer_tag | output | 9 | Retrieved tag |
| xfer_pat | output | 1 | Retrieved pattern bit |
| xfer_bufsel | output | 1 | Retrieved buffer-select bit |
| xfer_dir | output | 1 | Retrieved direction bit |
| xfer_slot | output | 8 | Retrieved time slot |
| xfer_stream | output | 5 | Retrieved stream |
| xfer_subrate | output | 7 | Retrieved subrate field |

## Verification
A corrupt valid flag shows up at the latest on the next make, search or read of that location. The result appears on the done pulse three cycles after issue, as a wrong index, a missed or spurious hit, or a lost entry when the memory is filled. A wrong pipelined index or a stale retrieval register shows up on the same done pulse, as data from another location. A lost overflow flag shows up as soon as the memory is filled to 512 entries and one more make is issued. A sequencer that accepts work while busy shows up as an extra entry or a missing done pulse.

// File: rtl/cam_conn_pkg.sv
package cam_conn_pkg;
  localparam int SLOT_W   = 8;
  localparam int STREAM_W = 5;
  localparam int TAG_LO_W = 8;
  localparam int TAG_W    = TAG_LO_W + 1;
  localparam int SUB_W    = 7;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_MAKE      = 3'd1,
    OP_BREAK     = 3'd2,
    OP_SEARCH    = 3'd3,
    OP_READ      = 3'd4,
    OP_CLEAR     = 3'd5,
    OP_RESET_ALL = 3'd6,
    OP_RSVD      = 3'd7
  } cam_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MATCH = 2'd1,
    ST_RETR  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [SLOT_W-1:0]   slot;
    logic [STREAM_W-1:0] stream;
    logic                dir;
    logic                pat;
    logic                bufsel;
    logic [TAG_W-1:0]    tag;
    logic [SUB_W-1:0]    subrate;
  } cam_entry_t;
endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N  = 512,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  // lowest set bit wins: scan from the top so the last hit is the lowest
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cam_entry_store.sv
module cam_entry_store
  import cam_conn_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [AW-1:0]       wr_idx,
  input  cam_entry_t          wr_data,
  input  logic                clr_one,
  input  logic [AW-1:0]       clr_idx,
  input  logic                clr_all,
  input  logic [SLOT_W-1:0]   key_slot,
  input  logic [STREAM_W-1:0] key_stream,
  input  logic                key_dir,
  input  logic [AW-1:0]       rd_idx,
  output cam_entry_t          rd_data,
  output logic                rd_valid,
  output logic [DEPTH-1:0]    valid_vec,
  output logic [DEPTH-1:0]    match_vec
);
  logic [DEPTH-1:0] valid_q, valid_d;
  cam_entry_t       mem_q [DEPTH];

  always_comb begin
    valid_d = valid_q;
    if (clr_all) begin
      valid_d = '0;
    end else begin
      if (clr_one) valid_d[clr_idx] = 1'b0;
      if (wr_en)   valid_d[wr_idx]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // payload storage carries no reset; validity gates every use
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = valid_q[g]
                       && (mem_q[g].slot   == key_slot)
                       && (mem_q[g].stream == key_stream)
                       && (mem_q[g].dir    == key_dir);
  end

  assign valid_vec = valid_q;
  assign rd_data   = mem_q[rd_idx];
  assign rd_valid  = valid_q[rd_idx];

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> (valid_vec == '0)); // R12
  AST_WRITE_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all) |=> valid_vec[$past(wr_idx)]); // R4
  AST_DROP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_one && !wr_en) |=> !valid_vec[$past(clr_idx)]); // R11
endmodule

// File: rtl/cam_conn_engine.sv
module cam_conn_engine
  import cam_conn_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [2:0]          cmd_op,
  input  logic [AW-1:0]       cmd_lar,
  input  logic [SLOT_W-1:0]   hold_slot,
  input  logic [STREAM_W-1:0] hold_stream,
  input  logic                hold_dir,
  input  logic                hold_pat,
  input  logic                hold_bufsel,
  input  logic [TAG_LO_W-1:0] hold_tag_lo,
  input  logic                hold_tag_hi,
  input  logic [SUB_W-1:0]    hold_subrate,
  input  logic                err_clear,
  output logic                busy,
  output logic                done,
  output logic                err_overflow,
  output logic                xfer_hit,
  output logic [AW-1:0]       xfer_index,
  output logic [TAG_W-1:0]    xfer_tag,
  output logic                xfer_pat,
  output logic                xfer_bufsel,
  output logic                xfer_dir,
  output logic [SLOT_W-1:0]   xfer_slot,
  output logic [STREAM_W-1:0] xfer_stream,
  output logic [SUB_W-1:0]    xfer_subrate
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      arst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      arst_n     <= rst_meta_q;
    end
  end

  seq_state_e state_q, state_d;
  cam_op_e    op_q, op_d;
  cam_entry_t hold_q, hold_d;
  logic [AW-1:0] lar_q, lar_d;
  logic          pf_q, pf_d;
  logic [AW-1:0] pi_q, pi_d;
  logic          done_q, done_d;
  logic          ovf_q, ovf_d;
  logic          xhit_q, xhit_d;
  logic [AW-1:0] xidx_q, xidx_d;
  cam_entry_t    xent_q, xent_d;

  logic          wr_en, clr_one, clr_all;
  cam_entry_t    rd_data;
  logic          rd_valid;
  logic [DEPTH-1:0] valid_vec, match_vec;
  logic          free_found, hit_found;
  logic [AW-1:0] free_idx, hit_idx;
  logic          cmd_legal, cmd_go;

  cam_entry_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (arst_n),
    .wr_en      (wr_en),
    .wr_idx     (pi_q),
    .wr_data    (hold_q),
    .clr_one    (clr_one),
    .clr_idx    (pi_q),
    .clr_all    (clr_all),
    .key_slot   (hold_q.slot),
    .key_stream (hold_q.stream),
    .key_dir    (hold_q.dir),
    .rd_idx     (pi_q),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .valid_vec  (valid_vec),
    .match_vec  (match_vec)
  );

  cam_prio_enc #(.N(DEPTH)) u_free (
    .req   (~valid_vec),
    .found (free_found),
    .idx   (free_idx)
  );

  cam_prio_enc #(.N(DEPTH)) u_hit (
    .req   (match_vec),
    .found (hit_found),
    .idx   (hit_idx)
  );

  assign cmd_legal = (cmd_op != 3'd0) && (cmd_op != 3'd7);
  assign cmd_go    = cmd_valid && cmd_legal && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    op_d    = op_q;
    hold_d  = hold_q;
    lar_d   = lar_q;
    pf_d    = pf_q;
    pi_d    = pi_q;
    done_d  = 1'b0;
    ovf_d   = err_clear ? 1'b0 : ovf_q;
    xhit_d  = xhit_q;
    xidx_d  = xidx_q;
    xent_d  = xent_q;
    wr_en   = 1'b0;
    clr_one = 1'b0;
    clr_all = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_go) begin
          state_d        = ST_MATCH;
          op_d           = cam_op_e'(cmd_op);
          lar_d          = cmd_lar;
          hold_d.slot    = hold_slot;
          hold_d.stream  = hold_stream;
          hold_d.dir     = hold_dir;
          hold_d.pat     = hold_pat;
          hold_d.bufsel  = hold_bufsel;
          hold_d.tag     = {hold_tag_hi, hold_tag_lo};
          hold_d.subrate = hold_subrate;
        end
      end
      ST_MATCH: begin
        state_d = ST_RETR;
        case (op_q)
          OP_MAKE:             begin pf_d = free_found; pi_d = free_idx; end
          OP_BREAK, OP_SEARCH: begin pf_d = hit_found;  pi_d = hit_idx;  end
          default:             begin pf_d = 1'b1;       pi_d = lar_q;    end
        endcase
      end
      ST_RETR: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        case (op_q)
          OP_MAKE: begin
            wr_en  = pf_q;
            if (!pf_q) ovf_d = 1'b1;
            xhit_d = pf_q;
            xidx_d = pf_q ? pi_q : '0;
          end
          OP_BREAK: begin
            clr_one = pf_q;
            xhit_d  = pf_q;
            xidx_d  = pf_q ? pi_q : '0;
          end
          OP_SEARCH: begin
            xhit_d = pf_q;
            xidx_d = pf_q ? pi_q : '0;
            xent_d = pf_q ? rd_data : '0;
          end
          OP_READ: begin
            xhit_d = rd_valid;
            xidx_d = pi_q;
            xent_d = rd_data;
          end
          OP_CLEAR:     clr_one = 1'b1;
          OP_RESET_ALL: clr_all = 1'b1;
          default: ;
        endcase
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      hold_q  <= '0;
      lar_q   <= '0;
      pf_q    <= 1'b0;
      pi_q    <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
      xhit_q  <= 1'b0;
      xidx_q  <= '0;
      xent_q  <= '0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      hold_q  <= hold_d;
      lar_q   <= lar_d;
      pf_q    <= pf_d;
      pi_q    <= pi_d;
      done_q  <= done_d;
      ovf_q   <= ovf_d;
      xhit_q  <= xhit_d;
      xidx_q  <= xidx_d;
      xent_q  <= xent_d;
    end
  end

  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign err_overflow = ovf_q;
  assign xfer_hit     = xhit_q;
  assign xfer_index   = xidx_q;
  assign xfer_tag     = xent_q.tag;
  assign xfer_pat     = xent_q.pat;
  assign xfer_bufsel  = xent_q.bufsel;
  assign xfer_dir     = xent_q.dir;
  assign xfer_slot    = xent_q.slot;
  assign xfer_stream  = xent_q.stream;
  assign xfer_subrate = xent_q.subrate;

  AST_TWO_CYCLE_BUSY: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(busy) |=> (busy ##1 (!busy && done))); // R2
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!arst_n)
    busy |=> (state_q != ST_MATCH)); // R3
  AST_PICK_IS_FREE: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_MATCH && op_q == OP_MAKE && free_found) |-> !valid_vec[free_idx]); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ovf_q) |-> $past(&valid_vec)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!arst_n)
    (ovf_q && !err_clear) |=> ovf_q); // R6
  AST_SEARCH_KEY_EQUAL: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_RETR && op_q == OP_SEARCH && pf_q) |->
      (rd_valid && rd_data.slot == hold_q.slot && rd_data.stream == hold_q.stream
       && rd_data.dir == hold_q.dir)); // R8 R9
endmodule

// File: tb/tb_cam_conn_engine.sv
`timescale 1ns/1ps
module tb_cam_conn_engine;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_lar;
  logic [7:0] hold_slot;
  logic [4:0] hold_stream;
  logic hold_dir, hold_pat, hold_bufsel, hold_tag_hi, err_clear;
  logic [7:0] hold_tag_lo;
  logic [6:0] hold_subrate;
  logic busy, done, err_overflow, xfer_hit, xfer_pat, xfer_bufsel, xfer_dir;
  logic [AW-1:0] xfer_index;
  logic [8:0] xfer_tag;
  logic [7:0] xfer_slot;
  logic [4:0] xfer_stream;
  logic [6:0] xfer_subrate;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cam_conn_engine dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_lar(cmd_lar),
    .hold_slot(hold_slot), .hold_stream(hold_stream), .hold_dir(hold_dir),
    .hold_pat(hold_pat), .hold_bufsel(hold_bufsel), .hold_tag_lo(hold_tag_lo),
    .hold_tag_hi(hold_tag_hi), .hold_subrate(hold_subrate), .err_clear(err_clear),
    .busy(busy), .done(done), .err_overflow(err_overflow), .xfer_hit(xfer_hit),
    .xfer_index(xfer_index), .xfer_tag(xfer_tag), .xfer_pat(xfer_pat),
    .xfer_bufsel(xfer_bufsel), .xfer_dir(xfer_dir), .xfer_slot(xfer_slot),
    .xfer_stream(xfer_stream), .xfer_subrate(xfer_subrate)
  );

  typedef struct packed {
    logic [2:0] op;
    logic [7:0] slot;
    logic [4:0] stream;
    logic       dir;
    logic [1:0] ctl;
    logic [8:0] tag;
    logic [6:0] sub;
    logic [8:0] lar;
    logic       chk;
    logic       chk_data;
    logic       e_hit;
    logic [8:0] e_idx;
    logic [8:0] e_tag;
    logic [1:0] e_ctl;
    logic [6:0] e_sub;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 8'd5, 5'd3, 1'b0, 2'b10, 9'h1A5, 7'h11, 9'd0, 1'b1, 1'b0, 1'b1, 9'd0, 9'h0,   2'b00, 7'h00},
    '{3'd1, 8'd5, 5'd3, 1'b1, 2'b01, 9'h033, 7'h22, 9'd0, 1'b1, 1'b0, 1'b1, 9'd1, 9'h0,   2'b00, 7'h00},
    '{3'd1, 8'd9, 5'd0, 1'b0, 2'b00, 9'h100, 7'h7F, 9'd0, 1'b1, 1'b0, 1'b1, 9'd2, 9'h0,   2'b00, 7'h00},
    '{3'd3, 8'd5, 5'd3, 1'b1, 2'b00, 9'h000, 7'h00, 9'd0, 1'b1, 1'b1, 1'b1, 9'd1, 9'h033, 2'b01, 7'h22},
    '{3'd3, 8'd5, 5'd3, 1'b0, 2'b00, 9'h000, 7'h00, 9'd0, 1'b1, 1'b1, 1'b1, 9'd0, 9'h1A5, 2'b10, 7'h11},
    '{3'd3, 8'd6, 5'd3, 1'b0, 2'b00, 9'h000, 7'h00, 9'd0, 1'b1, 1'b1, 1'b0, 9'd0, 9'h000, 2'b00, 7'h00},
    '{3'd4, 8'd0, 5'd0, 1'b0, 2'b00, 9'h000, 7'h00, 9'd2, 1'b1, 1'b1, 1'b1, 9'd2, 9'h100, 2'b00, 7'h7F},
    '{3'd2, 8'd5, 5'd3, 1'b0, 2'b00, 9'h000, 7'h00, 9'd0, 1'b1, 1'b0, 1'b1, 9'd0, 9'h0,   2'b00, 7'h00},
    '{3'd3, 8'd5, 5'd3, 1'b0, 2'b00, 9'h000, 7'h00, 9'd0, 1'b1, 1'b1, 1'b0, 9'd0, 9'h000, 2'b00, 7'h00},
    '{3'd2, 8'd5, 5'd3, 1'b0, 2'b00, 9'h000, 7'h00, 9'd0, 1'b1, 1'b0, 1'b0, 9'd0, 9'h0,   2'b00, 7'h00},
    '{3'd1, 8'd7, 5'd1, 1'b1, 2'b11, 9'h0EE, 7'h05, 9'd0, 1'b1, 1'b0, 1'b1, 9'd0, 9'h0,   2'b00, 7'h00},
    '{3'd4, 8'd0, 5'd0, 1'b0, 2'b00, 9'h000, 7'h00, 9'd0, 1'b1, 1'b1, 1'b1, 9'd0, 9'h0EE, 2'b11, 7'h05},
    '{3'd5, 8'd0, 5'd0, 1'b0, 2'b00, 9'h000, 7'h00, 9'd1, 1'b0, 1'b0, 1'b0, 9'd0, 9'h0,   2'b00, 7'h00},
    '{3'd4, 8'd0, 5'd0, 1'b0, 2'b00, 9'h000, 7'h00, 9'd1, 1'b1, 1'b0, 1'b0, 9'd1, 9'h0,   2'b00, 7'h00},
    '{3'd4, 8'd0, 5'd0, 1'b0, 2'b00, 9'h000, 7'h00, 9'd3, 1'b1, 1'b0, 1'b0, 9'd3, 9'h0,   2'b00, 7'h00}
  };

  function automatic string op_req(logic [2:0] op);
    case (op)
      3'd1: return "R4";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R10";
      3'd5: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive_hold(logic [2:0] op, logic [7:0] slot, logic [4:0] stream, logic dir,
                            logic [1:0] ctl, logic [8:0] tag, logic [6:0] sub, logic [8:0] lar);
    cmd_op = op; hold_slot = slot; hold_stream = stream; hold_dir = dir;
    hold_pat = ctl[1]; hold_bufsel = ctl[0];
    hold_tag_hi = tag[8]; hold_tag_lo = tag[7:0]; hold_subrate = sub; cmd_lar = lar;
  endtask

  // issue at a negedge, return at the negedge that shows done
  task automatic issue(logic [2:0] op, logic [7:0] slot, logic [4:0] stream, logic dir,
                       logic [1:0] ctl, logic [8:0] tag, logic [6:0] sub, logic [8:0] lar);
    int cnt;
    drive_hold(op, slot, stream, dir, ctl, tag, sub, lar);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt = 1;
    while (!done && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    if (cnt != 3) check("R2", "done latency", 32'(cnt), 32'd3);
  endtask

  task automatic do_read(logic [8:0] lar);
    issue(3'd4, 8'd0, 5'd0, 1'b0, 2'b00, 9'd0, 7'd0, lar);
  endtask

  task automatic do_make(logic [7:0] slot, logic [4:0] stream, logic [8:0] tag);
    issue(3'd1, slot, stream, 1'b0, 2'b00, tag, 7'd0, 9'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; err_clear = 1'b0;
    drive_hold(3'd0, 8'd0, 5'd0, 1'b0, 2'b00, 9'd0, 7'd0, 9'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1", "busy", 32'(busy), 0);
    check("R1", "done", 32'(done), 0);
    check("R1", "err_overflow", 32'(err_overflow), 0);
    check("R1", "xfer_hit", 32'(xfer_hit), 0);
    do_read(9'd0);   check("R1", "loc0 valid", 32'(xfer_hit), 0);
    do_read(9'd511); check("R1", "loc511 valid", 32'(xfer_hit), 0);

    // table walk; row 3 relies on direction separating two keys (R9)
    for (int v = 0; v < NV; v++) begin
      issue(VECS[v].op, VECS[v].slot, VECS[v].stream, VECS[v].dir, VECS[v].ctl,
            VECS[v].tag, VECS[v].sub, VECS[v].lar);
      if (VECS[v].chk) begin
        check(op_req(VECS[v].op), $sformatf("row %0d hit", v), 32'(xfer_hit), 32'(VECS[v].e_hit));
        check(op_req(VECS[v].op), $sformatf("row %0d index", v), 32'(xfer_index), 32'(VECS[v].e_idx));
      end
      if (VECS[v].chk_data) begin
        check(op_req(VECS[v].op), $sformatf("row %0d tag", v), 32'(xfer_tag), 32'(VECS[v].e_tag));
        check(op_req(VECS[v].op), $sformatf("row %0d ctl", v), 32'({xfer_pat, xfer_bufsel}), 32'(VECS[v].e_ctl));
        check(op_req(VECS[v].op), $sformatf("row %0d subrate", v), 32'(xfer_subrate), 32'(VECS[v].e_sub));
      end
      if (v == 3) check("R9", "dir-distinct hit index", 32'(xfer_index), 32'd1);
    end
    // read row 6 also returns key fields
    do_read(9'd2);
    check("R10", "slot", 32'(xfer_slot), 32'd9);
    check("R10", "stream", 32'(xfer_stream), 32'd0);
    check("R10", "dir", 32'(xfer_dir), 32'd0);

    // R3: request raised while busy is dropped (locations 0 and 2 valid now)
    drive_hold(3'd1, 8'd20, 5'd2, 1'b0, 2'b00, 9'h055, 7'd0, 9'd0);
    cmd_valid = 1'b1;
    @(negedge clk);
    drive_hold(3'd1, 8'd21, 5'd2, 1'b0, 2'b00, 9'h066, 7'd0, 9'd0);
    check("R3", "busy after accept", 32'(busy), 1);
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    check("R3", "done of first", 32'(done), 1);
    check("R4", "first make index", 32'(xfer_index), 32'd1);
    @(negedge clk);
    check("R3", "no second start", 32'(busy), 0);
    do_read(9'd3);
    check("R3", "blocked make stored", 32'(xfer_hit), 0);

    // R2: reserved opcodes ignored
    drive_hold(3'd7, 8'd0, 5'd0, 1'b0, 2'b00, 9'd0, 7'd0, 9'd0);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 3'd0;
    check("R2", "opcode 7 busy", 32'(busy), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R2", "opcode 0 busy", 32'(busy), 0);
    @(negedge clk);
    check("R2", "no done", 32'(done), 0);

    // R12 wipe
    issue(3'd6, 8'd0, 5'd0, 1'b0, 2'b00, 9'd0, 7'd0, 9'd0);
    do_read(9'd0); check("R12", "loc0 after wipe", 32'(xfer_hit), 0);
    do_read(9'd2); check("R12", "loc2 after wipe", 32'(xfer_hit), 0);

    // fill to capacity
    for (int i = 0; i < 512; i++) begin
      do_make(8'(i), 5'(i >> 8), 9'(i));
      check("R4", $sformatf("fill %0d index", i), 32'(xfer_index), 32'(i));
    end
    check("R5", "no overflow yet", 32'(err_overflow), 0);
    do_make(8'd200, 5'd9, 9'h1FF);
    check("R5", "full make hit", 32'(xfer_hit), 0);
    check("R5", "overflow set", 32'(err_overflow), 1);
    do_read(9'd0);
    check("R5", "loc0 kept tag", 32'(xfer_tag), 32'd0);
    do_read(9'd511);
    check("R5", "loc511 kept tag", 32'(xfer_tag), 32'd511);
    check("R5", "loc511 valid", 32'(xfer_hit), 1);

    // R6 sticky
    repeat (5) @(negedge clk);
    check("R6", "still set", 32'(err_overflow), 1);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    check("R6", "cleared", 32'(err_overflow), 0);
    do_read(9'd7);
    check("R6", "stays clear", 32'(err_overflow), 0);

    // R11 clear then reuse
    issue(3'd5, 8'd0, 5'd0, 1'b0, 2'b00, 9'd0, 7'd0, 9'd100);
    do_read(9'd100);
    check("R11", "loc100 dropped", 32'(xfer_hit), 0);
    do_make(8'd33, 5'd4, 9'h0AB);
    check("R4", "reuse index", 32'(xfer_index), 32'd100);
    check("R4", "reuse hit", 32'(xfer_hit), 1);
    do_read(9'd100);
    check("R4", "reuse tag", 32'(xfer_tag), 32'h0AB);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule